// File: doc/BRIEF.md
# Per-Pin Trigger-Selectable Interrupt Detector

This block watches a bank of general-purpose pins, arranged as four ports of eight pins each, and turns selected pin activity into interrupt requests. Each pin has its own trigger mode: rising edge, falling edge, both edges, high level or low level. When a pin's trigger condition is met, the detector sets that pin's sticky status bit. The bit stays set until software asks for it to be cleared.

The pin inputs must already be synchronized to the block clock. Per-port enable, trigger-type and clear vectors come in as plain inputs, because register decoding belongs to the surrounding logic. A pin counts as pending when both its status bit and its enable bit are set. A single bank interrupt line is the OR of all pending pins. Status bits collect events even while a pin is not enabled, so software can poll them or unmask a pin later.

Top module: `pin_irq_detector`

## Requirements
- R1: While reset is active, and directly after it, every status bit, every pending bit and the bank interrupt are 0.
- R2: Port p owns the 24-bit slice type_cfg[24p+23:24p]. For pin n of that port, bit n is the polarity (1 selects high level or rising edge), bit n+8 selects edge mode (1) instead of level mode (0), and bit n+16 selects both edges. The pin's global index is 8p+n.
- R3: Code (n+16, n+8, n) = 0,1,1 selects rising edge. The status bit sets on the clock at which the pin sample is 1 and the previous sample was 0.
- R4: Code 0,1,0 selects falling edge. The status bit sets on the clock at which the sample is 0 and the previous sample was 1.
- R5: Code 1,1,x selects both edges. The status bit sets on any change between consecutive samples, and the polarity bit has no effect.
- R6: Code 0,0,1 sets the status bit on every clock with the pin high. Code 0,0,0 sets it on every clock with the pin low. In level mode the both-edges bit has no effect.
- R7: A 1 in bit i of clr_req clears status bit i at the next clock. A 0 leaves the bit unchanged.
- R8: When a trigger condition and a clear request hit the same pin in the same clock, the status bit ends up set.
- R9: In level mode, a status bit cleared while its level is still active sets again at the next clock.
- R10: pending[i] equals status[i] AND irq_en[i]. bank_irq is the OR of all pending bits.
- R11: Status bits record triggers even when the pin's enable bit is 0.
- R12: Edges are found by comparing each sample with the sample from the previous clock. No edge is reported on the first clock after reset, because that clock has no previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronized pin samples, index 8*port+pin |
| irq_en | input | 32 | Per-pin interrupt enable |
| type_cfg | input | 96 | Trigger-type words, 24 bits per port |
| clr_req | input | 32 | Write-one-to-clear request for status bits |
| status | output | 32 | Sticky per-pin status |
| pending | output | 32 | Status masked by enable |
| bank_irq | output | 1 | Combined bank interrupt |

## Verification
The assertions assume that pin_in has already been synchronized, so each sample is stable around the rising clock edge. They also assume that clr_req is a one-clock pulse. The bench changes every input only at the falling clock edge and drives clear requests for exactly one step, so both assumptions hold. Trigger-type words may change between any two clocks. The level and set-wins properties read the current configuration, so they stay valid when software reprograms a pin while it is active.

// File: rtl/pid_pkg.sv
package pid_pkg;

  // Decide whether one pin meets its trigger condition this clock.
  function automatic logic pid_hit(
    input logic cur,
    input logic prev,
    input logic armed,
    input logic pol,
    input logic edge_mode,
    input logic dual
  );
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (!edge_mode) return pol ? cur : ~cur;
    if (!armed) return 1'b0;
    if (dual) return rise | fall;
    return pol ? rise : fall;
  endfunction

endpackage

// File: rtl/pid_pin_cell.sv
module pid_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic cur,
  input  logic pol,
  input  logic edge_mode,
  input  logic dual,
  input  logic clr,
  output logic hit,
  output logic status
);
  import pid_pkg::*;

  logic prev_q;
  logic stat_q;

  assign hit    = pid_hit(cur, prev_q, armed, pol, edge_mode, dual);
  assign status = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= cur;
      if (hit)      stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pid_port.sv
module pid_port #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic [PINS-1:0]   pins,
  input  logic [PINS-1:0]   en,
  input  logic [3*PINS-1:0] type_word,
  input  logic [PINS-1:0]   clr,
  output logic [PINS-1:0]   hit,
  output logic [PINS-1:0]   status,
  output logic [PINS-1:0]   pending
);
  // The type word holds three bit planes: polarity, edge mode, both edges.
  logic [PINS-1:0] pol_plane;
  logic [PINS-1:0] edge_plane;
  logic [PINS-1:0] dual_plane;

  assign pol_plane  = type_word[PINS-1:0];
  assign edge_plane = type_word[2*PINS-1:PINS];
  assign dual_plane = type_word[3*PINS-1:2*PINS];

  for (genvar b = 0; b < PINS; b++) begin : g_cell
    pid_pin_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .cur       (pins[b]),
      .pol       (pol_plane[b]),
      .edge_mode (edge_plane[b]),
      .dual      (dual_plane[b]),
      .clr       (clr[b]),
      .hit       (hit[b]),
      .status    (status[b])
    );
  end

  assign pending = status & en;
endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_PINS = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PORTS*PORT_PINS-1:0]     pin_in,
  input  logic [NUM_PORTS*PORT_PINS-1:0]     irq_en,
  input  logic [NUM_PORTS*3*PORT_PINS-1:0]   type_cfg,
  input  logic [NUM_PORTS*PORT_PINS-1:0]     clr_req,
  output logic [NUM_PORTS*PORT_PINS-1:0]     status,
  output logic [NUM_PORTS*PORT_PINS-1:0]     pending,
  output logic                               bank_irq
);
  localparam int NPIN = NUM_PORTS * PORT_PINS;
  localparam int TW   = 3 * PORT_PINS;

  // Edge detection waits for one real previous sample after reset.
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // Per-pin trigger events, brought out for the checker.
  logic [NPIN-1:0] set_evt;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pid_port #(.PINS(PORT_PINS)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed_q),
      .pins      (pin_in [p*PORT_PINS +: PORT_PINS]),
      .en        (irq_en [p*PORT_PINS +: PORT_PINS]),
      .type_word (type_cfg[p*TW +: TW]),
      .clr       (clr_req[p*PORT_PINS +: PORT_PINS]),
      .hit       (set_evt[p*PORT_PINS +: PORT_PINS]),
      .status    (status [p*PORT_PINS +: PORT_PINS]),
      .pending   (pending[p*PORT_PINS +: PORT_PINS])
    );
  end

  assign bank_irq = |pending;
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_PINS = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_PORTS*PORT_PINS-1:0]   pin_in,
  input logic [NUM_PORTS*PORT_PINS-1:0]   irq_en,
  input logic [NUM_PORTS*3*PORT_PINS-1:0] type_cfg,
  input logic [NUM_PORTS*PORT_PINS-1:0]   clr_req,
  input logic [NUM_PORTS*PORT_PINS-1:0]   status,
  input logic                             bank_irq,
  input logic [NUM_PORTS*PORT_PINS-1:0]   set_evt
);
  localparam int NPIN = NUM_PORTS * PORT_PINS;
  localparam int TW   = 3 * PORT_PINS;

  // R10: bank line follows the masked status
  a_r10_bank_or: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq == |(status & irq_en));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int P = i / PORT_PINS;
    localparam int B = i % PORT_PINS;
    logic lvl_hi;
    assign lvl_hi = !type_cfg[P*TW + PORT_PINS + B] && type_cfg[P*TW + B];

    // R8: a trigger always leaves the bit set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> status[i]);

    // R7: clear without trigger empties the bit
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !set_evt[i]) |=> !status[i]);

    // R7: no clear and no trigger keeps the bit
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req[i] && !set_evt[i]) |=> $stable(status[i]));

    // R9: active high level forces the bit set next clock
    a_r9_level_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_hi && pin_in[i]) |=> status[i]);
  end
endmodule

bind pin_irq_detector pid_checker #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_PINS (PORT_PINS)
) u_pid_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_in   (pin_in),
  .irq_en   (irq_en),
  .type_cfg (type_cfg),
  .clr_req  (clr_req),
  .status   (status),
  .bank_irq (bank_irq),
  .set_evt  (set_evt)
);

// File: tb/pin_irq_detector_bench.sv
`timescale 1ns/1ps
module pin_irq_detector_bench;
  localparam int NPIN = 32;
  localparam int TWB  = 96;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pins_d = '0;
  logic [NPIN-1:0] en_d = '0;
  logic [TWB-1:0]  cfg_d = '0;
  logic [NPIN-1:0] clr_d = '0;
  logic [NPIN-1:0] status;
  logic [NPIN-1:0] pending;
  logic            bank_irq;

  always #2.5 clk = ~clk;

  pin_irq_detector u_pin_irq_detector (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pins_d),
    .irq_en   (en_d),
    .type_cfg (cfg_d),
    .clr_req  (clr_d),
    .status   (status),
    .pending  (pending),
    .bank_irq (bank_irq)
  );

  typedef struct {
    logic [NPIN-1:0] st;
    logic [NPIN-1:0] en;
    string           tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state of the bench's own model
  logic [NPIN-1:0] m_stat = '0;
  logic [NPIN-1:0] m_prev = '0;
  bit              m_armed = 0;

  function automatic logic [TWB-1:0] put_code(logic [TWB-1:0] t, int pin, logic [2:0] code);
    int p = pin / 8;
    int b = pin % 8;
    t[p*24 + b]      = code[0];
    t[p*24 + 8 + b]  = code[1];
    t[p*24 + 16 + b] = code[2];
    return t;
  endfunction

  function automatic logic [2:0] get_code(logic [TWB-1:0] t, int pin);
    int p = pin / 8;
    int b = pin % 8;
    return {t[p*24 + 16 + b], t[p*24 + 8 + b], t[p*24 + b]};
  endfunction

  task automatic check(input string tag, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one clock of stimulus, predict, push the expectation
  task automatic step(input logic [NPIN-1:0] p, input logic [NPIN-1:0] e,
                      input logic [TWB-1:0] t, input logic [NPIN-1:0] c, input string tag);
    logic [NPIN-1:0] nxt;
    @(negedge clk);
    pins_d = p; en_d = e; cfg_d = t; clr_d = c;
    for (int i = 0; i < NPIN; i++) begin
      logic h;
      case (get_code(t, i))
        3'b011:          h = m_armed && p[i] && !m_prev[i];
        3'b010:          h = m_armed && !p[i] && m_prev[i];
        3'b110, 3'b111:  h = m_armed && (p[i] != m_prev[i]);
        3'b001, 3'b101:  h = p[i];
        default:         h = !p[i];
      endcase
      nxt[i] = h ? 1'b1 : (m_stat[i] & ~c[i]);
    end
    @(posedge clk);
    m_stat  = nxt;
    m_prev  = p;
    m_armed = 1;
    q.push_back('{st: nxt, en: e, tag: tag});
  endtask

  // Monitor: compare each expectation just after its clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(it.tag, status, it.st);
        check({it.tag, "/R10 pending"}, pending, it.st & it.en);
        check({it.tag, "/R10 irq"}, {31'd0, bank_irq}, {31'd0, |(it.st & it.en)});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TWB-1:0]  base;
    logic [TWB-1:0]  t;
    logic [NPIN-1:0] p;
    logic [31:0]     lf;
    base = '0;
    for (int i = 0; i < NPIN; i++) base = put_code(base, i, 3'b011);
    cfg_d  = base;
    pins_d = 32'h0000_0020;  // pin 5 already high in reset

    repeat (3) @(posedge clk);
    #1;
    check("R1 status in reset", status, '0);
    check("R1 irq in reset", {31'd0, bank_irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R12: pin 5 high from reset is not an edge
    p = 32'h0000_0020;
    step(p, '1, base, '0, "R12 first clock");
    step(p, '1, base, '0, "R12 steady");
    // R3 rising on pin 0
    p[0] = 1; step(p, '1, base, '0, "R3 rise");
    p[0] = 0; step(p, '1, base, '0, "R3 fall ignored");
    step(p, '1, base, 32'h1, "R7 clear");
    step(p, '1, base, '0, "R7 stays clear");
    p[0] = 1; step(p, '1, base, '0, "R3 rise again");
    step(p, '1, base, 32'h2, "R7 other clear no effect");
    step(p, '1, base, 32'h1, "R7 clear pin0");
    // R4 falling on pin 9
    t = put_code(base, 9, 3'b010);
    p[9] = 1; step(p, '1, t, '0, "R4 rise ignored");
    p[9] = 0; step(p, '1, t, '0, "R4 fall");
    step(p, '1, t, 32'h200, "R7 clear pin9");
    // R5 both edges on pin 17, polarity set too
    t = put_code(t, 17, 3'b111);
    p[17] = 1; step(p, '1, t, '0, "R5 up");
    step(p, '1, t, 32'h2_0000, "R7 clear pin17");
    p[17] = 0; step(p, '1, t, '0, "R5 down");
    step(p, '1, t, 32'h2_0000, "R7 clear pin17 again");
    // R6/R9 high level on pin 24 (with both-edges bit set: ignored)
    t = put_code(t, 24, 3'b101);
    p[24] = 1; step(p, '1, t, '0, "R6 high level");
    step(p, '1, t, 32'h0100_0000, "R9 cleared while high");
    step(p, '1, t, '0, "R9 re-set");
    p[24] = 0; step(p, '1, t, 32'h0100_0000, "R9 clear after low");
    step(p, '1, t, '0, "R6 low no set");
    // R6 low level on pin 30
    t = put_code(t, 30, 3'b000);
    step(p, '1, t, '0, "R6 low level");
    p[30] = 1; step(p, '1, t, 32'h4000_0000, "R6 clear when high");
    // R8 trigger plus clear on pin 0
    p[0] = 0; step(p, '1, t, '0, "R8 prep");
    p[0] = 1; step(p, '1, t, 32'h1, "R8 set wins");
    // R11/R10: enables off, then on
    p[1] = 1; step(p, '0, t, '0, "R11 record masked");
    step(p, 32'h0000_0002, t, '0, "R10 enable one");
    step(p, 32'h8000_0000, t, '0, "R10 enable idle pin");
    step(p, '0, t, '1, "R10 clear all");
    // R2: mixed field positions in every port
    t = put_code(t, 7, 3'b010);
    t = put_code(t, 15, 3'b001);
    t = put_code(t, 23, 3'b110);
    t = put_code(t, 31, 3'b011);
    p[7] = 1; p[23] = 0; p[31] = 0;
    step(p, '1, t, '1, "R2 setup");
    p[7] = 0; p[15] = 1; p[23] = 1; p[31] = 1;
    step(p, '1, t, '0, "R2 per-port decode");
    // Mixed phase: pseudo-random pins, enables, types, clears
    lf = 32'hACE1_1234;
    for (int k = 0; k < 60; k++) begin
      logic [NPIN-1:0] e;
      logic [NPIN-1:0] c;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      p = lf ^ {lf[15:0], lf[31:16]};
      e = {lf[7:0], lf[31:8]};
      c = lf & {lf[3:0], lf[31:4]} & {lf[9:0], lf[31:10]};
      if (k % 10 == 0) t = {lf, ~lf, lf ^ 32'h5A5A_5A5A};
      step(p, e, t, c, "R2 mixed");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule